// File: doc/BRIEF.md
# Transmit Descriptor Poll Timer

This block paces the re-scan of a network controller's transmit descriptor ring. A free-running poll counter advances once per clock while the controller is running. When it runs off its top, the block raises a one-clock poll strobe and restarts the count from a start value taken from a programmable interval register. The interval is programmed as the two's complement of the wanted period, in clock units. Its four lowest bits play no part, and a seventeenth bit is taken to be one, so every 16-bit value is a positive period and zero selects the longest one.

Both the counter and the interval register sit behind a small word-wide register port. That port is open only while the controller is stopped or suspended; accesses at any other time are dropped. Neither register is touched by the block reset. An initialization pulse returns the interval to its default of zero and restarts the count from the matching start value. The surrounding descriptor engine consumes the strobe, and software uses the port to read or retune the timer while the controller is halted.

Top module: `txpoll_timer`

## Requirements
- R1: A cycle with `init_i` high sets the interval register to 0000h and the counter to 0000h, overriding any write or count in that cycle.
- R2: While `run_en` is high, `poll_o` is high for exactly one clock each time the counter passes FFFFh, and the counter restarts from the start value in that same edge, giving a period of 65,536 minus the start value clocks. The start value is interval bits [15:4] followed by four zero bits.
- R3: Interval bits [3:0] have no effect on the period, although they are stored and read back.
- R4: An interval of 0000h gives a period of 65,536 clocks.
- R5: While `run_en` is low the counter holds its value and `poll_o` stays low.
- R6: A write (`reg_wr` high) is applied only when `stop_i` or `susp_i` is high; at other times neither register changes.
- R7: `reg_rdata` is all zeros unless `reg_rd` is high and `stop_i` or `susp_i` is high.
- R8: Register word bits [31:16] read as zero and bits written there are discarded.
- R9: A low `rst_n` clears `poll_o` and stops counting, but leaves the counter and interval values as they were.
- R10: A new interval value changes only the start value of the next restart; the running count continues from where it was.
- R11: `reg_sel` = 0 selects the counter and `reg_sel` = 1 the interval; an allowed write loads bits [15:0] of `reg_wdata` into the selected register, and an allowed read returns its current 16-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (strobe and counting only) |
| init_i | input | 1 | Initialization pulse, loads the default interval |
| run_en | input | 1 | Controller running; counter advances while high |
| stop_i | input | 1 | Controller stopped; opens the register port |
| susp_i | input | 1 | Controller suspended; opens the register port |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_sel | input | 1 | 0 = poll counter, 1 = interval register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| poll_o | output | 1 | One-clock transmit poll strobe |

## Verification
On every cycle the assertions check that a strobe never lasts longer than one clock and always coincides with a counter equal to the current start value, that the counter holds while the controller is idle, that writes outside stop or suspend leave the interval untouched, that closed or idle reads and the reserved upper half are zero, and that the initialization pulse lands on the defaults. Whether the strobe spacing actually equals the programmed period, that the low nibble makes no difference, that the zero interval yields the full 65,536-clock period, that a retuned interval waits for the next restart, and that reset preserves both values can only be shown by the bench's scenarios, which compare against a behavioural model each clock and measure gaps between strobes.

// File: rtl/txpoll_pkg.sv
// Package: shared constants and types for the transmit poll timer.
// Assumes a 32-bit register word holding a 16-bit value.
package txpoll_pkg;

    localparam int unsigned TP_WORD_W = 32;
    localparam int unsigned TP_VAL_W  = 16;
    localparam int unsigned TP_IGN_W  = 4;

    // Register select encoding used on the access port.
    typedef enum logic {
        TP_SEL_COUNT = 1'b0,
        TP_SEL_INTVL = 1'b1
    } tp_sel_e;

endpackage

// File: rtl/txpoll_access.sv
// Module: txpoll_access
// Gates the register port on the stop/suspend state, decodes the
// select into per-register write enables and muxes the read data.
// Assumes reads are combinational and the reserved upper part of the
// word is always zero.
module txpoll_access #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned VAL_W  = 16
) (
    input  logic              stop_i,
    input  logic              susp_i,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [VAL_W-1:0]  cnt_val,
    input  logic [VAL_W-1:0]  iv_val,
    output logic              cnt_we,
    output logic              iv_we,
    output logic              wr_any,
    output logic [VAL_W-1:0]  wval,
    output logic [DATA_W-1:0] reg_rdata
);
    import txpoll_pkg::*;

    localparam int unsigned PAD_W = DATA_W - VAL_W;

    logic             port_open;
    logic             rd_ok;
    logic [VAL_W-1:0] rd_val;
    tp_sel_e          sel;

    // Purpose: the port is open only while stopped or suspended.
    always_comb begin
        port_open = stop_i | susp_i;
        sel       = tp_sel_e'(reg_sel);
        wr_any    = reg_wr & port_open;
        rd_ok     = reg_rd & port_open;
    end

    // Purpose: decode the select into one write enable per register.
    always_comb begin
        cnt_we = 1'b0;
        iv_we  = 1'b0;
        if (wr_any) begin
            unique case (sel)
                TP_SEL_COUNT: cnt_we = 1'b1;
                TP_SEL_INTVL: iv_we  = 1'b1;
                default: ;
            endcase
        end
    end

    // Purpose: keep only the value bits of the write word.
    always_comb begin
        wval = reg_wdata[VAL_W-1:0];
    end

    // Purpose: select the read value, zero when the read is not allowed.
    always_comb begin
        rd_val = '0;
        if (rd_ok) begin
            unique case (sel)
                TP_SEL_COUNT: rd_val = cnt_val;
                TP_SEL_INTVL: rd_val = iv_val;
                default:      rd_val = '0;
            endcase
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            logic unused_wr_hi;
            // Purpose: reserved write bits are discarded.
            always_comb unused_wr_hi = ^reg_wdata[DATA_W-1:VAL_W];
            // Purpose: reserved read bits are driven as zero.
            always_comb reg_rdata = {{PAD_W{1'b0}}, rd_val};
        end else begin : g_nopad
            // Purpose: word and value have the same width.
            always_comb reg_rdata = rd_val;
        end
    endgenerate

endmodule

// File: rtl/txpoll_interval.sv
// Module: txpoll_interval
// Holds the programmed interval and derives the counter start value
// from it: the low IGN_W bits are replaced by zeros, and the implied
// top bit is left out because the counter keeps it implicitly.
// Assumes the register is not touched by reset; only the init pulse
// loads the default of zero.
module txpoll_interval #(
    parameter int unsigned VAL_W = 16,
    parameter int unsigned IGN_W = 4
) (
    input  logic             clk,
    input  logic             init_i,
    input  logic             we,
    input  logic [VAL_W-1:0] wval,
    output logic [VAL_W-1:0] iv_q,
    output logic [VAL_W-1:0] start_val
);

    // Purpose: load the default on init, otherwise accept allowed writes.
    always_ff @(posedge clk) begin
        if (init_i) begin
            iv_q <= '0;
        end else if (we) begin
            iv_q <= wval;
        end
    end

    generate
        if (IGN_W > 0) begin : g_mask
            // Purpose: clear the ignored granularity bits.
            always_comb start_val = {iv_q[VAL_W-1:IGN_W], {IGN_W{1'b0}}};
        end else begin : g_full
            // Purpose: every bit is significant.
            always_comb start_val = iv_q;
        end
    endgenerate

endmodule

// File: rtl/txpoll_counter.sv
// Module: txpoll_counter
// Poll time counter. The stored value is the low VAL_W bits of a
// count whose top bit is always one, so passing all-ones is the
// carry out of the implied bit. On that carry it reloads from the
// start value and raises a registered one-clock strobe.
// Assumes rst_n only clears the strobe and halts counting; the count
// itself survives reset and is set by init or by an allowed write.
module txpoll_counter #(
    parameter int unsigned VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             run_en,
    input  logic             wr_any,
    input  logic             we,
    input  logic [VAL_W-1:0] wval,
    input  logic [VAL_W-1:0] start_val,
    output logic [VAL_W-1:0] cnt_q,
    output logic             poll_q
);

    logic             adv;
    logic             wrap;
    logic [VAL_W-1:0] cnt_nx;

    // Purpose: advance only when running, out of reset, and no access or init.
    always_comb begin
        adv  = rst_n & run_en & ~init_i & ~wr_any;
        wrap = &cnt_q;
    end

    // Purpose: next count with priority init, write, advance.
    always_comb begin
        cnt_nx = cnt_q;
        if (init_i) begin
            cnt_nx = '0;
        end else if (we) begin
            cnt_nx = wval;
        end else if (adv) begin
            cnt_nx = wrap ? start_val : cnt_q + 1'b1;
        end
    end

    // Purpose: the count register, not reset.
    always_ff @(posedge clk) begin
        cnt_q <= cnt_nx;
    end

    // Purpose: one-clock strobe on the carry out of the implied top bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_q <= 1'b0;
        end else begin
            poll_q <= adv & wrap;
        end
    end

endmodule

// File: rtl/txpoll_timer.sv
// Module: txpoll_timer (top)
// Transmit descriptor poll timer: programmable interval register,
// poll time counter and a gated register port. Emits poll_o once per
// programmed period while run_en is high.
// Assumes stop_i/susp_i/run_en come from the controller state machine
// and init_i is a pulse from the initialization sequence.
module txpoll_timer #(
    parameter int unsigned DATA_W = txpoll_pkg::TP_WORD_W,
    parameter int unsigned VAL_W  = txpoll_pkg::TP_VAL_W,
    parameter int unsigned IGN_W  = txpoll_pkg::TP_IGN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              run_en,
    input  logic              stop_i,
    input  logic              susp_i,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              poll_o
);

    logic             cnt_we;
    logic             iv_we;
    logic             wr_any;
    logic [VAL_W-1:0] wval;
    logic [VAL_W-1:0] cnt_q;
    logic [VAL_W-1:0] iv_q;
    logic [VAL_W-1:0] start_val;
    logic             poll_q;

    txpoll_access #(
        .DATA_W (DATA_W),
        .VAL_W  (VAL_W)
    ) u_access (
        .stop_i    (stop_i),
        .susp_i    (susp_i),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .cnt_val   (cnt_q),
        .iv_val    (iv_q),
        .cnt_we    (cnt_we),
        .iv_we     (iv_we),
        .wr_any    (wr_any),
        .wval      (wval),
        .reg_rdata (reg_rdata)
    );

    txpoll_interval #(
        .VAL_W (VAL_W),
        .IGN_W (IGN_W)
    ) u_interval (
        .clk       (clk),
        .init_i    (init_i),
        .we        (iv_we),
        .wval      (wval),
        .iv_q      (iv_q),
        .start_val (start_val)
    );

    txpoll_counter #(
        .VAL_W (VAL_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (init_i),
        .run_en    (run_en),
        .wr_any    (wr_any),
        .we        (cnt_we),
        .wval      (wval),
        .start_val (start_val),
        .cnt_q     (cnt_q),
        .poll_q    (poll_q)
    );

    // Purpose: drive the strobe output from the counter's register.
    always_comb poll_o = poll_q;

endmodule

// File: rtl/txpoll_timer_chk.sv
// Module: txpoll_timer_chk
// Property checker for txpoll_timer, attached with bind below.
// Assumes the default widths of a 32-bit word and a 16-bit value.
module txpoll_timer_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned VAL_W  = 16,
    parameter int unsigned IGN_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_i,
    input logic              run_en,
    input logic              stop_i,
    input logic              susp_i,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              poll_o,
    input logic [VAL_W-1:0]  cnt_q,
    input logic [VAL_W-1:0]  iv_q
);

    logic port_open;
    always_comb port_open = stop_i | susp_i;

    // R2: the strobe never lasts two clocks
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        poll_o |=> !poll_o);

    // R2: a strobe coincides with the counter restarted at the start value
    a_r2_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        poll_o |-> (cnt_q[VAL_W-1:IGN_W] == iv_q[VAL_W-1:IGN_W]
                    && cnt_q[IGN_W-1:0] == '0));

    // R5: counter holds while not running and not accessed
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !init_i && !(reg_wr && port_open)) |=> $stable(cnt_q));

    // R5: no strobe follows an idle cycle
    a_r5_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !poll_o);

    // R6: closed-port writes leave the interval alone
    a_r6_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !port_open && !init_i) |=> $stable(iv_q));

    // R7: closed or idle reads return zero
    a_r7_read_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && port_open) |-> (reg_rdata == '0));

    // R8: reserved half always reads zero
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:VAL_W] == '0);

    // R1: init lands both registers on zero
    a_r1_init_default: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (iv_q == '0 && cnt_q == '0));

endmodule

bind txpoll_timer txpoll_timer_chk #(
    .DATA_W (DATA_W),
    .VAL_W  (VAL_W),
    .IGN_W  (IGN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_i    (init_i),
    .run_en    (run_en),
    .stop_i    (stop_i),
    .susp_i    (susp_i),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .poll_o    (poll_o),
    .cnt_q     (cnt_q),
    .iv_q      (iv_q)
);

// File: tb/txpoll_timer_tb.sv
// Bench for txpoll_timer: behavioural model compared every clock,
// plus scenario checks on strobe spacing and register access.
module txpoll_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_i = 1'b1;
    logic        run_en = 1'b0;
    logic        stop_i = 1'b1;
    logic        susp_i = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        poll_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // model state
    int m_cnt = 0;
    int m_iv = 0;
    bit m_poll = 0;
    bit m_valid = 0;

    int strobes[$];

    always #5 clk = ~clk;

    txpoll_timer u_dut (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .run_en(run_en),
        .stop_i(stop_i), .susp_i(susp_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .poll_o(poll_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Behavioural model, updated on every rising edge.
    always @(posedge clk) begin
        bit wr_ok, adv, np;
        wr_ok = reg_wr && (stop_i || susp_i);
        adv = rst_n && run_en && !init_i && !wr_ok;
        np = adv && (m_cnt == 65535);
        if (init_i) begin
            m_iv = 0; m_cnt = 0; m_valid = 1;
        end else if (wr_ok) begin
            if (reg_sel) m_iv = int'(reg_wdata[15:0]);
            else m_cnt = int'(reg_wdata[15:0]);
        end else if (adv) begin
            m_cnt = (m_cnt == 65535) ? (m_iv & 32'hFFF0) : m_cnt + 1;
        end
        m_poll = np;
        cyc++;
    end

    // Per-clock comparison away from the edge.
    always @(negedge clk) begin
        #2;
        if (m_valid && !done) begin
            longint exp_rd;
            check("R2 poll strobe vs model", poll_o, m_poll);
            exp_rd = 0;
            if (reg_rd && (stop_i || susp_i)) exp_rd = reg_sel ? m_iv : m_cnt;
            check("R7/R11 read data vs model", reg_rdata, exp_rd);
            if (poll_o) strobes.push_back(cyc);
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 200000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input bit sel, input longint exp, input string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_sel = sel;
        #3;
        check(tag, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_strobes(input int n);
        int guard = 0;
        while (strobes.size() < n && guard < 150000) begin
            @(negedge clk); guard++;
        end
        #4;
    endtask

    initial begin
        // R1: init during reset, then release
        idle(3);
        init_i = 1'b0;
        rst_n = 1'b1;
        idle(1);
        check("R9 poll low after reset", poll_o, 0);
        rd(1'b0, 0, "R1 counter default");
        rd(1'b1, 0, "R1 interval default");

        // R8/R11: program interval, upper bits discarded
        wr(1'b1, 32'hABCD_FFC5);
        rd(1'b1, 32'h0000_FFC5, "R8 upper bits discarded, R11 interval readback");
        wr(1'b0, 32'h1234_FFC0);
        rd(1'b0, 32'h0000_FFC0, "R11 counter readback");

        // R2/R3: period 64 despite low nibble 5
        strobes.delete();
        @(negedge clk); stop_i = 1'b0; run_en = 1'b1;
        wait_strobes(3);
        check("R2 R3 gap 1 with low nibble ignored", strobes[1] - strobes[0], 64);
        check("R2 gap 2", strobes[2] - strobes[1], 64);

        // R5: counter holds while idle
        @(negedge clk); run_en = 1'b0; stop_i = 1'b1;
        idle(2);
        begin
            longint v1;
            @(negedge clk); reg_rd = 1'b1; reg_sel = 1'b0; #3; v1 = reg_rdata;
            idle(10); #3;
            check("R5 counter held while idle", reg_rdata, v1);
            @(negedge clk); reg_rd = 1'b0;
        end

        // R6/R7: closed port ignores writes and reads zero
        @(negedge clk); stop_i = 1'b0;
        wr(1'b1, 32'h0000_1234);
        @(negedge clk); reg_rd = 1'b1; reg_sel = 1'b1; #3;
        check("R7 closed-port read is zero", reg_rdata, 0);
        @(negedge clk); reg_rd = 1'b0; susp_i = 1'b1;
        rd(1'b1, 32'h0000_FFC5, "R6 closed-port write ignored");

        // R10: new interval, counter untouched, applies at next restart
        @(negedge clk); reg_rd = 1'b1; reg_sel = 1'b0; #3;
        begin
            longint c0;
            c0 = reg_rdata;
            @(negedge clk); reg_rd = 1'b0;
            wr(1'b1, 32'h0000_FF80);
            rd(1'b0, c0, "R10 counter unchanged by interval write");
        end
        strobes.delete();
        @(negedge clk); susp_i = 1'b0; run_en = 1'b1;
        wait_strobes(3);
        check("R10 new period after restart", strobes[2] - strobes[1], 128);
        check("R10 first restart used new start", strobes[1] - strobes[0], 128);

        // R9: reset keeps values, clears strobe
        @(negedge clk); run_en = 1'b0; stop_i = 1'b1;
        wr(1'b0, 32'h0000_1357);
        wr(1'b1, 32'h0000_F00F);
        @(negedge clk); rst_n = 1'b0; run_en = 1'b1;
        idle(3);
        check("R9 no strobe during reset", poll_o, 0);
        @(negedge clk); rst_n = 1'b1; run_en = 1'b0;
        rd(1'b0, 32'h0000_1357, "R9 counter kept over reset");
        rd(1'b1, 32'h0000_F00F, "R9 interval kept over reset");

        // R1/R4: init restores zero interval; full 65536 period
        @(negedge clk); init_i = 1'b1;
        @(negedge clk); init_i = 1'b0;
        rd(1'b1, 0, "R1 init restores interval");
        wr(1'b0, 32'h0000_FF00);
        strobes.delete();
        @(negedge clk); stop_i = 1'b0; run_en = 1'b1;
        wait_strobes(2);
        check("R4 zero interval gives 65536", strobes[1] - strobes[0], 65536);

        @(negedge clk); run_en = 1'b0;
        idle(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule